// File: doc/BRIEF.md
# Two-Wire Bus Slave Address Matcher

This block decides whether the first byte after a START or repeated START on a two-wire serial bus is addressed to the local node. The bit shifter upstream delivers the assembled byte with a one-cycle valid strobe. The bus-condition detector delivers one-cycle START and STOP pulses. The matcher compares the upper seven bits of the byte with a programmed node address. When general-call recognition is enabled, it also accepts the all-zero write address.

On a hit, the matcher produces several results. It emits a one-cycle match pulse and latches the direction bit. It flags whether the hit was a general call, and it raises a wake indication. It also latches the acknowledge decision for the ninth clock. That decision is an acknowledge only if a separate acknowledge-enable input was set when the byte arrived. The matcher is built from a few registers and a small comparator, so it can stay clocked while the rest of the node sleeps. All latched results stay in place until the next START or STOP.

Top module: `i2c_addr_match`

## Requirements
- R1: When an armed byte arrives whose bits [7:1] equal `own_addr_i` and are not all zero, `match_o` is high for exactly the one cycle after the strobe edge.
- R2: With `gc_en_i` = 1, an armed byte of 8'h00 is a match, and `gc_o` reads 1 from the cycle after the strobe.
- R3: With `gc_en_i` = 0, the byte 8'h00 is not a match. The byte 8'h01 (general call with the read bit) is never a match.
- R4: An address field of seven zero bits never matches through the own-address path, even when `own_addr_i` is zero.
- R5: On a match, `ack_o` = 1 (acknowledge) if `ack_en_i` was 1 with the strobe, and `ack_o` = 0 (not acknowledge) otherwise. After a miss, `ack_o` = 0.
- R6: On a match, `rw_o` holds bit 0 of the byte (1 = read). After a miss, `rw_o` = 0.
- R7: Only the first byte strobed after a START is evaluated. Later bytes, and bytes before any START since reset, give no match pulse and leave the results unchanged.
- R8: A START or STOP pulse clears `gc_o`, `rw_o`, `ack_o` and `wake_o` in the following cycle. A START re-arms evaluation and a STOP disarms it. A byte strobed in the same cycle as either pulse is ignored.
- R9: `wake_o` rises together with any match pulse, including a not-acknowledged one. It holds until the next START or STOP.
- R10: After reset, all outputs are 0 and the matcher is disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | START or repeated START seen (pulse) |
| stop_i | input | 1 | STOP seen (pulse) |
| byte_vld_i | input | 1 | Received byte valid (pulse) |
| byte_i | input | 8 | Received byte, bit 0 = R/W |
| own_addr_i | input | 7 | Programmed node address |
| gc_en_i | input | 1 | General-call recognition enable |
| ack_en_i | input | 1 | Acknowledge enable |
| match_o | output | 1 | Address hit (one-cycle pulse) |
| gc_o | output | 1 | Hit was a general call |
| rw_o | output | 1 | Latched direction bit of the hit |
| ack_o | output | 1 | 1 = drive acknowledge on the ninth clock |
| wake_o | output | 1 | Wake indication, held until START/STOP |

## Verification
Every result has a latency of one clock. The match pulse and the latched flags appear right after the edge that samples the strobe. A START or STOP clears the flags right after the edge that samples the pulse. The bench drives the inputs shortly after a rising edge and compares all five outputs with its model just after the next rising edge. The effect of each stimulus is therefore checked in the single cycle where it becomes due. The one-cycle width of the match pulse is checked on the following cycle.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;

   // Result of decoding one address byte
   typedef struct packed {
      logic hit;   // byte addresses this node
      logic gc;    // hit came through the general-call path
      logic rw;    // direction bit of the byte
   } am_decode_t;

   localparam logic AM_RW_WRITE = 1'b0;

endpackage

// File: rtl/am_field_cmp.sv
// Bitwise equality and all-zero detection of one address field
module am_field_cmp #(
   parameter int W = 7
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic         eq_o,
   output logic         a_zero_o
);
   if (W < 1) begin : g_bad_w
      $error("am_field_cmp: W must be at least 1");
   end

   logic [W-1:0] bit_eq;
   logic [W-1:0] bit_zero;

   for (genvar i = 0; i < W; i++) begin : g_bit
      assign bit_eq[i]   = ~(a_i[i] ^ b_i[i]);
      assign bit_zero[i] = ~a_i[i];
   end

   assign eq_o     = &bit_eq;
   assign a_zero_o = &bit_zero;
endmodule

// File: rtl/am_decode.sv
// Combinational address decode of one byte
module am_decode
   import i2c_am_pkg::*;
#(
   parameter int ADDR_W  = 7,
   parameter bit GC_IMPL = 1'b1,
   localparam int BYTE_W = ADDR_W + 1
) (
   input  logic [BYTE_W-1:0] byte_i,
   input  logic [ADDR_W-1:0] own_addr_i,
   input  logic              gc_en_i,
   output am_decode_t        dec_o
);
   logic [ADDR_W-1:0] field;
   logic              field_eq;
   logic              field_zero;
   logic              own_hit;
   logic              gc_hit;

   assign field = byte_i[BYTE_W-1:1];

   am_field_cmp #(.W(ADDR_W)) u_cmp (
      .a_i      (field),
      .b_i      (own_addr_i),
      .eq_o     (field_eq),
      .a_zero_o (field_zero)
   );

   // the all-zero field is reserved for the general call
   assign own_hit = field_eq & ~field_zero;

   if (GC_IMPL) begin : g_gc
      assign gc_hit = gc_en_i & field_zero & (byte_i[0] == AM_RW_WRITE);
   end else begin : g_no_gc
      logic unused_gc;
      assign unused_gc = gc_en_i;
      assign gc_hit    = 1'b0;
   end

   always_comb begin
      dec_o.hit = own_hit | gc_hit;
      dec_o.gc  = gc_hit;
      dec_o.rw  = byte_i[0];
   end
endmodule

// File: rtl/am_arm_ctrl.sv
// Tracks whether the next byte is the address byte of a transfer
module am_arm_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic stop_i,
   input  logic byte_vld_i,
   output logic take_o,
   output logic clear_o
);
   logic armed_q;

   assign clear_o = start_i | stop_i;
   assign take_o  = byte_vld_i & armed_q & ~clear_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       armed_q <= 1'b0;
      else if (clear_o) armed_q <= start_i;
      else if (take_o)  armed_q <= 1'b0;
   end
endmodule

// File: rtl/am_result_reg.sv
// Holds the outcome of the last evaluated address byte
module am_result_reg
   import i2c_am_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       take_i,
   input  logic       clear_i,
   input  am_decode_t dec_i,
   input  logic       ack_en_i,
   output logic       match_o,
   output logic       gc_o,
   output logic       rw_o,
   output logic       ack_o,
   output logic       wake_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         match_o <= 1'b0;
         gc_o    <= 1'b0;
         rw_o    <= 1'b0;
         ack_o   <= 1'b0;
         wake_o  <= 1'b0;
      end else if (clear_i) begin
         match_o <= 1'b0;
         gc_o    <= 1'b0;
         rw_o    <= 1'b0;
         ack_o   <= 1'b0;
         wake_o  <= 1'b0;
      end else if (take_i) begin
         match_o <= dec_i.hit;
         gc_o    <= dec_i.hit & dec_i.gc;
         rw_o    <= dec_i.hit & dec_i.rw;
         ack_o   <= dec_i.hit & ack_en_i;
         wake_o  <= wake_o | dec_i.hit;
      end else begin
         match_o <= 1'b0;
      end
   end
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
   import i2c_am_pkg::*;
#(
   parameter int ADDR_W  = 7,
   parameter bit GC_IMPL = 1'b1,
   localparam int BYTE_W = ADDR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              stop_i,
   input  logic              byte_vld_i,
   input  logic [BYTE_W-1:0] byte_i,
   input  logic [ADDR_W-1:0] own_addr_i,
   input  logic              gc_en_i,
   input  logic              ack_en_i,
   output logic              match_o,
   output logic              gc_o,
   output logic              rw_o,
   output logic              ack_o,
   output logic              wake_o
);
   if (ADDR_W < 2 || ADDR_W > 10) begin : g_bad_addr_w
      $error("i2c_addr_match: ADDR_W out of range 2..10");
   end

   logic       take;
   logic       clear;
   am_decode_t dec;

   am_arm_ctrl u_arm (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .stop_i     (stop_i),
      .byte_vld_i (byte_vld_i),
      .take_o     (take),
      .clear_o    (clear)
   );

   am_decode #(.ADDR_W(ADDR_W), .GC_IMPL(GC_IMPL)) u_dec (
      .byte_i     (byte_i),
      .own_addr_i (own_addr_i),
      .gc_en_i    (gc_en_i),
      .dec_o      (dec)
   );

   am_result_reg u_res (
      .clk      (clk),
      .rst_n    (rst_n),
      .take_i   (take),
      .clear_i  (clear),
      .dec_i    (dec),
      .ack_en_i (ack_en_i),
      .match_o  (match_o),
      .gc_o     (gc_o),
      .rw_o     (rw_o),
      .ack_o    (ack_o),
      .wake_o   (wake_o)
   );
endmodule

// File: rtl/am_checker.sv
module am_checker #(
   parameter int ADDR_W = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              stop_i,
   input logic              byte_vld_i,
   input logic [ADDR_W:0]   byte_i,
   input logic              gc_en_i,
   input logic              ack_en_i,
   input logic              match_o,
   input logic              gc_o,
   input logic              rw_o,
   input logic              ack_o,
   input logic              wake_o
);
   AST_MATCH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      match_o |=> !match_o); // R1

   AST_MATCH_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      match_o |-> $past(byte_vld_i && !start_i && !stop_i)); // R7

   AST_GC_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gc_o) |-> $past(gc_en_i && byte_i == '0)); // R3

   AST_ACK_FOLLOWS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      match_o |-> (ack_o == $past(ack_en_i))); // R5

   AST_RW_FOLLOWS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      match_o |-> (rw_o == $past(byte_i[0]))); // R6

   AST_CLEAR_ON_COND: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i || stop_i) |=> !(gc_o || rw_o || ack_o || wake_o || match_o)); // R8

   AST_WAKE_WITH_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      match_o |-> wake_o); // R9
endmodule

bind i2c_addr_match am_checker #(.ADDR_W(ADDR_W)) u_am_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .stop_i     (stop_i),
   .byte_vld_i (byte_vld_i),
   .byte_i     (byte_i),
   .gc_en_i    (gc_en_i),
   .ack_en_i   (ack_en_i),
   .match_o    (match_o),
   .gc_o       (gc_o),
   .rw_o       (rw_o),
   .ack_o      (ack_o),
   .wake_o     (wake_o)
);

// File: tb/tb_i2c_addr_match.sv
`timescale 1ns/1ps
module tb_i2c_addr_match;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0, stop_i = 1'b0, byte_vld_i = 1'b0;
   logic [7:0] byte_i = '0;
   logic [6:0] own_addr_i = '0;
   logic       gc_en_i = 1'b0, ack_en_i = 1'b0;
   logic       match_o, gc_o, rw_o, ack_o, wake_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // reference model state
   bit m_armed, m_match, m_gc, m_rw, m_ack, m_wake;

   always #4 clk = ~clk;

   i2c_addr_match dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
      .byte_vld_i(byte_vld_i), .byte_i(byte_i), .own_addr_i(own_addr_i),
      .gc_en_i(gc_en_i), .ack_en_i(ack_en_i), .match_o(match_o),
      .gc_o(gc_o), .rw_o(rw_o), .ack_o(ack_o), .wake_o(wake_o)
   );

   function automatic bit f_gc_hit(logic [7:0] b, logic gce);
      return gce && (b == 8'h00);
   endfunction

   function automatic bit f_hit(logic [7:0] b, logic [6:0] own, logic gce);
      bit own_hit;
      own_hit = (b[7:1] != 7'd0) && (b[7:1] == own);
      return own_hit || f_gc_hit(b, gce);
   endfunction

   task automatic chk(string req, logic act, bit exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
      end
   endtask

   task automatic check_all();
      chk("R1 match_o", match_o, m_match);
      chk("R2 gc_o",    gc_o,    m_gc);
      chk("R5 ack_o",   ack_o,   m_ack);
      chk("R6 rw_o",    rw_o,    m_rw);
      chk("R9 wake_o",  wake_o,  m_wake);
   endtask

   // one clock: drive, edge, update model, sample after the edge
   task automatic cyc(bit st, bit sp, bit vld, logic [7:0] b,
                      logic [6:0] own, bit gce, bit acke);
      bit h;
      start_i = st; stop_i = sp; byte_vld_i = vld; byte_i = b;
      own_addr_i = own; gc_en_i = gce; ack_en_i = acke;
      @(posedge clk);
      m_match = 1'b0;
      if (st || sp) begin
         m_armed = st; m_gc = 0; m_rw = 0; m_ack = 0; m_wake = 0;
      end else if (vld && m_armed) begin
         m_armed = 1'b0;
         h = f_hit(b, own, gce);
         m_match = h;
         m_gc  = h && f_gc_hit(b, gce);
         m_rw  = h && b[0];
         m_ack = h && acke;
         m_wake = m_wake || h;
      end
      #2;
      check_all();
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) cyc(0, 0, 0, 8'h00, own_addr_i, gc_en_i, ack_en_i);
   endtask

   initial begin
      #100000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(posedge clk);
      #2;
      // R10: reset state
      chk("R10 match_o", match_o, 0); chk("R10 gc_o", gc_o, 0);
      chk("R10 ack_o", ack_o, 0); chk("R10 wake_o", wake_o, 0);
      rst_n = 1'b1;

      // R7: byte before any START is ignored
      cyc(0, 0, 1, 8'hA4, 7'h52, 1, 1);
      chk("R7 no match unarmed", match_o, 0);

      // R1 R5 R6: own address write, acknowledged
      cyc(1, 0, 0, 8'h00, 7'h52, 1, 1);
      cyc(0, 0, 1, 8'hA4, 7'h52, 1, 1);
      chk("R1 own match", match_o, 1); chk("R5 ack", ack_o, 1); chk("R6 rw write", rw_o, 0);
      cyc(0, 0, 0, 8'h00, 7'h52, 1, 1);
      chk("R1 pulse width", match_o, 0); chk("R9 wake held", wake_o, 1);
      // R7: second byte gives no match, results held
      cyc(0, 0, 1, 8'hA4, 7'h52, 1, 0);
      chk("R7 later byte", match_o, 0); chk("R7 ack kept", ack_o, 1);

      // R5 R6 R9: repeated START, read, NACK
      cyc(1, 0, 0, 8'h00, 7'h52, 1, 0);
      chk("R8 cleared by START", wake_o, 0);
      cyc(0, 0, 1, 8'hA5, 7'h52, 1, 0);
      chk("R5 nack", ack_o, 0); chk("R6 rw read", rw_o, 1); chk("R9 wake on nack", wake_o, 1);

      // R2: general call enabled
      cyc(1, 0, 0, 8'h00, 7'h52, 1, 1);
      cyc(0, 0, 1, 8'h00, 7'h52, 1, 1);
      chk("R2 gc match", match_o, 1); chk("R2 gc flag", gc_o, 1);
      // R8: STOP clears
      cyc(0, 1, 0, 8'h00, 7'h52, 1, 1);
      chk("R8 STOP clears gc", gc_o, 0); chk("R8 STOP clears ack", ack_o, 0);
      cyc(0, 0, 1, 8'hA4, 7'h52, 1, 1);
      chk("R8 disarmed after STOP", match_o, 0);

      // R3: general call disabled, and read general call
      cyc(1, 0, 0, 8'h00, 7'h52, 0, 1);
      cyc(0, 0, 1, 8'h00, 7'h52, 0, 1);
      chk("R3 gc disabled", match_o, 0);
      cyc(1, 0, 0, 8'h00, 7'h52, 1, 1);
      cyc(0, 0, 1, 8'h01, 7'h52, 1, 1);
      chk("R3 gc read rejected", match_o, 0);

      // R4: own address zero never matches field zero
      cyc(1, 0, 0, 8'h00, 7'h00, 0, 1);
      cyc(0, 0, 1, 8'h00, 7'h00, 0, 1);
      chk("R4 zero field own", match_o, 0);
      cyc(1, 0, 0, 8'h00, 7'h00, 0, 1);
      cyc(0, 0, 1, 8'h01, 7'h00, 0, 1);
      chk("R4 zero field read", match_o, 0);

      // R8: byte in the same cycle as START is ignored, then evaluated
      cyc(1, 0, 1, 8'hA4, 7'h52, 1, 1);
      chk("R8 byte with START ignored", match_o, 0);
      cyc(0, 0, 1, 8'hA4, 7'h52, 1, 1);
      chk("R8 rearmed", match_o, 1);

      // random mix checked against the model every cycle
      for (int n = 0; n < 3000; n++) begin
         int r;
         logic [7:0] b;
         logic [6:0] own;
         r   = $urandom_range(0, 99);
         own = ($urandom_range(0, 3) == 0) ? 7'h00 : 7'h3C;
         case ($urandom_range(0, 3))
            0: b = {own, 1'($urandom_range(0, 1))};
            1: b = {7'h00, 1'($urandom_range(0, 1))};
            default: b = 8'($urandom_range(0, 255));
         endcase
         cyc(r < 15, (r >= 15 && r < 22), r >= 30 || r < 5, b, own,
             1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      end
      idle(2);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule